// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block walks a chain of descriptors held in memory and turns it into a series of data-move requests. A one-cycle start pulse hands it the address of the first descriptor. It reads each descriptor through a word-read request/acknowledge port and decodes the two action bits. Depending on the action, it skips the descriptor, records a byte length, jumps to another table, or hands an address and a byte length to a downstream mover and waits for that mover's done handshake. The mover, the memory and the card-side protocol belong to neighbouring blocks.

A mode input selects one of two descriptor layouts. In the one-word layout the address field is page aligned, and lengths come from separate set-length descriptors. In the two-word layout each descriptor carries its own 16-bit length and a full 32-bit address. The walker adds up the bytes it has moved. When the descriptor marked as last completes, it compares that sum with a programmed expected total. It reports completion, per-descriptor interrupt pulses and two sticky error flags, together with a 2-bit code that tells which phase of the walk the error was raised in.

Top module: `desc_walker`

## Requirements
- R1: After reset, busy, memReq, moveReq, done, irq, descErr and lenErr are 0 and errState is 0.
- R2: A start pulse while idle makes the first fetch read address tableBase and clears descErr, lenErr, errState, the byte total and the stored length.
- R3: Descriptor attribute bits are bit0 valid, bit1 end, bit2 interrupt and bits 5:4 action. If the first word of a descriptor is fetched with bit0 clear, descErr is set and errState becomes 1. The walk then stops with no done pulse and no move request.
- R4: In the one-word layout (mode64=0), action 01 stores bits 27:12 as the length. Action 10 issues moveAddr = bits 31:12 followed by 12 zero bits, with moveLen set to the last stored length (0 if none has been stored since start). moveReq and moveAddr hold until moveDone.
- R5: In the two-word layout (mode64=1), the word at the pointer holds the attributes and the length (bits 31:16), and the word at pointer+4 holds the 32-bit address. Action 10 moves that address and length.
- R6: Action 11 loads the fetch pointer with the descriptor's address. Every other completed descriptor advances the pointer by 4 (mode64=0) or by 8 (mode64=1).
- R7: Action 00 in both layouts, and action 01 in the two-word layout, are skipped without a move request.
- R8: A descriptor is rejected with descErr set and errState 2 if any of these holds: bit3 is set; the reserved bits (11:6 in the one-word layout, 15:6 in the two-word layout) are nonzero; or, in the two-word layout, a transfer or link address, or a transfer length, is not a multiple of 4. No move is issued for a rejected descriptor.
- R9: A descriptor with bit2 set raises irq for exactly one cycle, in the cycle after its action completes (for a transfer, after moveDone).
- R10: A descriptor with bit1 set ends the walk once its action completes. done pulses for one cycle, and busy is low in that same cycle.
- R11: When the walk ends and the byte total differs from expectedBytes, lenErr is set, errState becomes 3 and done still pulses. When they match, lenErr stays 0.
- R12: abort returns the walker to idle on the next cycle: busy and moveReq drop and no done follows.
- R13: A start pulse while busy is ignored, and the walk in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk at tableBase (accepted while idle) |
| abort | input | 1 | Return to idle immediately |
| mode64 | input | 1 | 1 selects the two-word layout, 0 the one-word layout |
| tableBase | input | 32 | Address of the first descriptor |
| expectedBytes | input | 32 | Byte total the walk is expected to move |
| memReq | output | 1 | Descriptor word read request |
| memAddr | output | 32 | Descriptor word address |
| memAck | input | 1 | Read acknowledge, memData valid |
| memData | input | 32 | Descriptor word read data |
| moveReq | output | 1 | Data-move request to the mover |
| moveAddr | output | 32 | Data-move start address |
| moveLen | output | 16 | Data-move byte length |
| moveDone | input | 1 | Mover finished the current request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at normal end of walk |
| irq | output | 1 | One-cycle pulse for descriptors with the interrupt bit |
| descErr | output | 1 | Sticky descriptor error |
| lenErr | output | 1 | Sticky length-mismatch error |
| errState | output | 2 | Phase of the last error: 0 stopped, 1 fetch, 2 address change, 3 data |

## Verification
The final descriptor of a chain can carry both the interrupt bit and the end bit. In that case the irq pulse and the done pulse come from the same completion and must appear in the same cycle, not one after the other. The two-word chain is built so that its last transfer has both bits set. A monitor counts the cycles in which irq and done are high together and expects exactly one such cycle, along with the total count of irq pulses. The bench also makes a start pulse arrive while a transfer is outstanding, and an abort arrive while moveReq is high. It then judges that the move list and the done count show no trace of the ignored start, and no completion after the abort.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_LO, ST_FETCH_HI, ST_DECODE, ST_MOVE
  } walkState_t;

  typedef enum logic [1:0] {
    ACT_NOP = 2'b00, ACT_LEN = 2'b01, ACT_XFER = 2'b10, ACT_LINK = 2'b11
  } action_t;

  localparam logic [1:0] CODE_STOP  = 2'd0;
  localparam logic [1:0] CODE_FETCH = 2'd1;
  localparam logic [1:0] CODE_ADDR  = 2'd2;
  localparam logic [1:0] CODE_DATA  = 2'd3;

  typedef struct packed {
    logic loadBase;
    logic latchLo;
    logic latchHi;
    logic fetchHi;
    logic setLen;
    logic linkPtr;
    logic advPtr;
    logic loadMove;
    logic addTotal;
  } dpCtl_t;
endpackage

// File: rtl/dwalk_datapath.sv
module dwalk_datapath
  import dwalk_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              mode64,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [CNT_W-1:0]  expectedBytes,
  input  logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] moveAddr,
  output logic [LEN_W-1:0]  moveLen,
  output logic              fetchValid,
  output logic              descEnd,
  output logic              descInt,
  output action_t           descAct,
  output logic              formatBad,
  output logic              matchNow,
  output logic              matchAfterMove
);
  localparam int PAGE_BITS = 12;
  localparam int LEN_LSB64 = 16;
  localparam int STEP32    = WORD_W / 8;
  localparam int STEP64    = 2 * STEP32;

  logic [ADDR_W-1:0] ptr;
  logic [WORD_W-1:0] wordLo, wordHi;
  logic [LEN_W-1:0]  lenReg, mvLen;
  logic [ADDR_W-1:0] mvAddr;
  logic [CNT_W-1:0]  total;
  logic [ADDR_W-1:0] descAddr, stepVal;
  logic [LEN_W-1:0]  descLen;
  logic              rsvdBad, alignBad;

  assign descAddr = mode64 ? wordHi : {wordLo[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  assign descLen  = mode64 ? wordLo[LEN_LSB64 +: LEN_W] : lenReg;
  assign stepVal  = mode64 ? ADDR_W'(STEP64) : ADDR_W'(STEP32);
  assign memAddr  = ctl.fetchHi ? ptr + ADDR_W'(STEP32) : ptr;

  assign fetchValid = memData[0];
  assign descEnd    = wordLo[1];
  assign descInt    = wordLo[2];
  assign descAct    = action_t'(wordLo[5:4]);

  // reserved-field check and two-word alignment check
  assign rsvdBad  = wordLo[3] | (|wordLo[11:6]) | (mode64 & (|wordLo[15:12]));
  assign alignBad = mode64 & ((wordLo[5] & (|wordHi[1:0])) |
                              ((descAct == ACT_XFER) & (|wordLo[LEN_LSB64 +: 2])));
  assign formatBad = rsvdBad | alignBad;

  assign matchNow       = (total == expectedBytes);
  assign matchAfterMove = ((total + CNT_W'(mvLen)) == expectedBytes);

  assign moveAddr = mvAddr;
  assign moveLen  = mvLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr    <= '0;
      wordLo <= '0;
      wordHi <= '0;
      lenReg <= '0;
      mvAddr <= '0;
      mvLen  <= '0;
      total  <= '0;
    end else begin
      if (ctl.loadBase) begin
        ptr    <= tableBase;
        total  <= '0;
        lenReg <= '0;
      end
      if (ctl.latchLo)  wordLo <= memData;
      if (ctl.latchHi)  wordHi <= memData;
      if (ctl.setLen)   lenReg <= wordLo[PAGE_BITS +: LEN_W];
      if (ctl.linkPtr)     ptr <= descAddr;
      else if (ctl.advPtr) ptr <= ptr + stepVal;
      if (ctl.loadMove) begin
        mvAddr <= descAddr;
        mvLen  <= descLen;
      end
      if (ctl.addTotal) total <= total + CNT_W'(mvLen);
    end
  end
endmodule

// File: rtl/dwalk_control.sv
module dwalk_control
  import dwalk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       abort,
  input  logic       mode64,
  input  logic       memAck,
  input  logic       moveDone,
  input  logic       fetchValid,
  input  logic       descEnd,
  input  logic       descInt,
  input  action_t    descAct,
  input  logic       formatBad,
  input  logic       matchNow,
  input  logic       matchAfterMove,
  output dpCtl_t     ctl,
  output logic       memReq,
  output logic       moveReq,
  output logic       busy,
  output logic       done,
  output logic       irq,
  output logic       descErr,
  output logic       lenErr,
  output logic [1:0] errState
);
  walkState_t state, nxt;
  logic       finish, matchSel;
  logic       irqSet, doneSet, descErrSet, lenErrSet;
  logic [1:0] errCode;

  always_comb begin
    ctl        = '0;
    nxt        = state;
    finish     = 1'b0;
    matchSel   = matchNow;
    irqSet     = 1'b0;
    doneSet    = 1'b0;
    descErrSet = 1'b0;
    lenErrSet  = 1'b0;
    errCode    = CODE_STOP;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.loadBase = 1'b1;
          nxt          = ST_FETCH_LO;
        end
      end
      ST_FETCH_LO: begin
        if (memAck) begin
          if (!fetchValid) begin
            descErrSet = 1'b1;
            errCode    = CODE_FETCH;
            nxt        = ST_IDLE;
          end else begin
            ctl.latchLo = 1'b1;
            nxt         = mode64 ? ST_FETCH_HI : ST_DECODE;
          end
        end
      end
      ST_FETCH_HI: begin
        ctl.fetchHi = 1'b1;
        if (memAck) begin
          ctl.latchHi = 1'b1;
          nxt         = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (formatBad) begin
          descErrSet = 1'b1;
          errCode    = CODE_ADDR;
          nxt        = ST_IDLE;
        end else begin
          case (descAct)
            ACT_XFER: begin
              ctl.loadMove = 1'b1;
              nxt          = ST_MOVE;
            end
            ACT_LINK: begin
              ctl.linkPtr = 1'b1;
              finish      = 1'b1;
            end
            ACT_LEN: begin
              ctl.setLen = !mode64;
              ctl.advPtr = 1'b1;
              finish     = 1'b1;
            end
            default: begin
              ctl.advPtr = 1'b1;
              finish     = 1'b1;
            end
          endcase
        end
      end
      ST_MOVE: begin
        if (moveDone) begin
          ctl.addTotal = 1'b1;
          ctl.advPtr   = 1'b1;
          finish       = 1'b1;
          matchSel     = matchAfterMove;
        end
      end
      default: nxt = ST_IDLE;
    endcase

    if (finish) begin
      irqSet = descInt;
      if (descEnd) begin
        doneSet   = 1'b1;
        lenErrSet = !matchSel;
        nxt       = ST_IDLE;
      end else begin
        nxt = ST_FETCH_LO;
      end
    end

    if (abort) begin
      ctl        = '0;
      nxt        = ST_IDLE;
      irqSet     = 1'b0;
      doneSet    = 1'b0;
      descErrSet = 1'b0;
      lenErrSet  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      irq      <= 1'b0;
      done     <= 1'b0;
      descErr  <= 1'b0;
      lenErr   <= 1'b0;
      errState <= CODE_STOP;
    end else begin
      state <= nxt;
      irq   <= irqSet;
      done  <= doneSet;
      if (ctl.loadBase) begin
        descErr  <= 1'b0;
        lenErr   <= 1'b0;
        errState <= CODE_STOP;
      end
      if (descErrSet) begin
        descErr  <= 1'b1;
        errState <= errCode;
      end
      if (lenErrSet) begin
        lenErr   <= 1'b1;
        errState <= CODE_DATA;
      end
    end
  end

  assign memReq  = (state == ST_FETCH_LO) || (state == ST_FETCH_HI);
  assign moveReq = (state == ST_MOVE);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/desc_walker.sv
module desc_walker
  import dwalk_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abort,
  input  logic              mode64,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [CNT_W-1:0]  expectedBytes,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [WORD_W-1:0] memData,
  output logic              moveReq,
  output logic [ADDR_W-1:0] moveAddr,
  output logic [LEN_W-1:0]  moveLen,
  input  logic              moveDone,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              descErr,
  output logic              lenErr,
  output logic [1:0]        errState
);
  dpCtl_t  ctl;
  logic    fetchValid, descEnd, descInt, formatBad, matchNow, matchAfterMove;
  action_t descAct;

  dwalk_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort), .mode64(mode64),
    .memAck(memAck), .moveDone(moveDone), .fetchValid(fetchValid),
    .descEnd(descEnd), .descInt(descInt), .descAct(descAct),
    .formatBad(formatBad), .matchNow(matchNow), .matchAfterMove(matchAfterMove),
    .ctl(ctl), .memReq(memReq), .moveReq(moveReq), .busy(busy), .done(done),
    .irq(irq), .descErr(descErr), .lenErr(lenErr), .errState(errState)
  );

  dwalk_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mode64(mode64), .tableBase(tableBase),
    .expectedBytes(expectedBytes), .memData(memData), .memAddr(memAddr),
    .moveAddr(moveAddr), .moveLen(moveLen), .fetchValid(fetchValid),
    .descEnd(descEnd), .descInt(descInt), .descAct(descAct),
    .formatBad(formatBad), .matchNow(matchNow), .matchAfterMove(matchAfterMove)
  );
endmodule

// File: rtl/desc_walker_chk.sv
module desc_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        abort,
  input logic        busy,
  input logic        done,
  input logic        irq,
  input logic        memReq,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic        moveReq,
  input logic        moveDone,
  input logic [31:0] moveAddr,
  input logic        descErr,
  input logic        lenErr,
  input logic [1:0]  errState
);
  // R12
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> !busy && !moveReq);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R4
  move_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    moveReq && !moveDone && !abort |=> moveReq && $stable(moveAddr));

  // R6
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !abort |=> memReq && $stable(memAddr));

  // R5
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && moveReq));

  // R3
  descerr_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(descErr) |-> (errState == 2'd1 || errState == 2'd2));

  // R11
  lenerr_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lenErr) |-> (errState == 2'd3) && done);
endmodule

bind desc_walker desc_walker_chk u_chk (
  .clk(clk), .rstN(rstN), .abort(abort), .busy(busy), .done(done), .irq(irq),
  .memReq(memReq), .memAck(memAck), .memAddr(memAddr), .moveReq(moveReq),
  .moveDone(moveDone), .moveAddr(moveAddr), .descErr(descErr),
  .lenErr(lenErr), .errState(errState)
);

// File: tb/desc_walker_tb.sv
module desc_walker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, abort = 1'b0, mode64 = 1'b0;
  logic [31:0] tableBase = '0, expectedBytes = '0;
  logic        memReq, memAck, moveReq, moveDone;
  logic [31:0] memAddr, memData, moveAddr;
  logic [15:0] moveLen;
  logic        busy, done, irq, descErr, lenErr;
  logic [1:0]  errState;

  always #4 clk = ~clk;

  desc_walker u_dut (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort), .mode64(mode64),
    .tableBase(tableBase), .expectedBytes(expectedBytes), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memData(memData), .moveReq(moveReq),
    .moveAddr(moveAddr), .moveLen(moveLen), .moveDone(moveDone), .busy(busy),
    .done(done), .irq(irq), .descErr(descErr), .lenErr(lenErr), .errState(errState)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [512];
  logic [31:0] fetchLog [64];
  logic [31:0] moveLogA [16];
  logic [15:0] moveLogL [16];
  int fetchCnt, moveCnt, irqCnt, doneCnt, bothCnt;
  int mvWait;

  localparam logic [5:0] A_END = 6'h02, A_INT = 6'h04;
  localparam logic [5:0] A_NOP = 6'h01, A_LEN = 6'h11, A_XF = 6'h21, A_LK = 6'h31;

  function automatic logic [8:0] idx(input logic [31:0] a);
    return {a[13:12], a[8:2]};
  endfunction
  function automatic logic [31:0] d32(input logic [31:0] a, input logic [5:0] at);
    return {a[31:12], 6'b0, at};
  endfunction
  function automatic logic [31:0] len32(input logic [15:0] l, input logic [5:0] at);
    return {4'b0, l, 6'b0, at};
  endfunction
  function automatic logic [31:0] lo64(input logic [15:0] l, input logic [5:0] at);
    return {l, 10'b0, at};
  endfunction

  task automatic memW(input logic [31:0] a, input logic [31:0] v);
    mem[idx(a)] = v;
  endtask

  // memory responder: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else begin
      memAck  <= memReq && !memAck;
      memData <= mem[idx(memAddr)];
    end
  end

  // mover responder: done after three request cycles
  always @(posedge clk) begin
    if (!rstN) begin
      moveDone <= 1'b0;
      mvWait   <= 0;
    end else if (moveReq && !moveDone) begin
      if (mvWait == 2) begin
        moveDone <= 1'b1;
        mvWait   <= 0;
      end else mvWait <= mvWait + 1;
    end else begin
      moveDone <= 1'b0;
      mvWait   <= 0;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (memReq && memAck && fetchCnt < 64) begin
        fetchLog[fetchCnt] = memAddr;
        fetchCnt++;
      end
      if (moveReq && moveDone && moveCnt < 16) begin
        moveLogA[moveCnt] = moveAddr;
        moveLogL[moveCnt] = moveLen;
        moveCnt++;
      end
      if (irq) irqCnt++;
      if (done) doneCnt++;
      if (irq && done) bothCnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expV);
    checks++;
    if (act !== expV) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expV);
    end
  endtask

  task automatic clearLogs();
    fetchCnt = 0; moveCnt = 0; irqCnt = 0; doneCnt = 0; bothCnt = 0;
  endtask

  task automatic kick(input logic [31:0] base, input logic m64, input logic [31:0] expB);
    @(negedge clk);
    tableBase = base; mode64 = m64; expectedBytes = expB;
    clearLogs();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runChain(input logic [31:0] base, input logic m64, input logic [31:0] expB);
    kick(base, m64, expB);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic buildChain32();
    memW(32'h1000, len32(16'h0200, A_LEN));
    memW(32'h1004, d32(32'h5000, A_XF | A_INT));
    memW(32'h1008, {26'b0, A_NOP});
    memW(32'h100C, d32(32'h2000, A_LK));
    memW(32'h2000, len32(16'h0040, A_LEN));
    memW(32'h2004, d32(32'h7000, A_XF | A_END));
  endtask

  task automatic testReset();
    chk("R1 busy", busy, 0);
    chk("R1 memReq", memReq, 0);
    chk("R1 moveReq", moveReq, 0);
    chk("R1 done", done, 0);
    chk("R1 irq", irq, 0);
    chk("R1 descErr", descErr, 0);
    chk("R1 lenErr", lenErr, 0);
    chk("R1 errState", errState, 0);
  endtask

  task automatic testChain32();
    buildChain32();
    runChain(32'h1000, 1'b0, 32'h240);
    chk("R2 first fetch", fetchLog[0], 32'h1000);
    chk("R4 move count", moveCnt, 2);
    chk("R4 move0 addr", moveLogA[0], 32'h5000);
    chk("R4 move0 len", moveLogL[0], 16'h0200);
    chk("R4 move1 addr", moveLogA[1], 32'h7000);
    chk("R4 move1 len", moveLogL[1], 16'h0040);
    chk("R6 fetch count", fetchCnt, 6);
    chk("R6 step4", fetchLog[3], 32'h100C);
    chk("R6 link", fetchLog[4], 32'h2000);
    chk("R9 irq count", irqCnt, 1);
    chk("R10 done count", doneCnt, 1);
    chk("R11 no lenErr", lenErr, 0);
    chk("R3 no descErr", descErr, 0);
  endtask

  task automatic testChain64();
    memW(32'h0100, lo64(16'h0010, A_XF | A_INT));  memW(32'h0104, 32'h3000);
    memW(32'h0108, lo64(16'h0000, A_LEN));         memW(32'h010C, 32'h1234_5678);
    memW(32'h0110, lo64(16'h0000, A_NOP));         memW(32'h0114, 32'h0);
    memW(32'h0118, lo64(16'h0000, A_LK));          memW(32'h011C, 32'h2040);
    memW(32'h2040, lo64(16'h0020, A_XF | A_END | A_INT)); memW(32'h2044, 32'h3100);
    runChain(32'h0100, 1'b1, 32'h30);
    chk("R5 high word fetch", fetchLog[1], 32'h0104);
    chk("R5 move0 addr", moveLogA[0], 32'h3000);
    chk("R5 move0 len", moveLogL[0], 16'h0010);
    chk("R5 move1 addr", moveLogA[1], 32'h3100);
    chk("R5 move1 len", moveLogL[1], 16'h0020);
    chk("R7 skipped no move", moveCnt, 2);
    chk("R7 step8 past reserved", fetchLog[4], 32'h0110);
    chk("R6 link64", fetchLog[8], 32'h2040);
    chk("R6 fetch count64", fetchCnt, 10);
    chk("R9 irq count64", irqCnt, 2);
    chk("R10 irq with done", bothCnt, 1);
    chk("R10 done64", doneCnt, 1);
    chk("R11 match64", lenErr, 0);
  endtask

  task automatic testInvalid();
    memW(32'h1000, len32(16'h0020, A_LEN));
    memW(32'h1004, 32'h0);
    runChain(32'h1000, 1'b0, 32'h20);
    chk("R3 descErr", descErr, 1);
    chk("R3 errState", errState, 1);
    chk("R3 no done", doneCnt, 0);
    chk("R3 no move", moveCnt, 0);
    chk("R3 stopped", busy, 0);
  endtask

  task automatic testFormat();
    memW(32'h0100, lo64(16'h0012, A_XF | A_END)); memW(32'h0104, 32'h3000);
    runChain(32'h0100, 1'b1, 32'h12);
    chk("R8 misaligned len", descErr, 1);
    chk("R8 errState", errState, 2);
    chk("R8 no move", moveCnt, 0);
    chk("R8 no done", doneCnt, 0);
    memW(32'h1000, 32'h0000_0009);
    runChain(32'h1000, 1'b0, 32'h0);
    chk("R8 bit3 set", descErr, 1);
    chk("R8 bit3 errState", errState, 2);
  endtask

  task automatic testLength();
    memW(32'h1000, len32(16'h0100, A_LEN));
    memW(32'h1004, d32(32'h4000, A_XF | A_END));
    runChain(32'h1000, 1'b0, 32'h80);
    chk("R11 lenErr", lenErr, 1);
    chk("R11 errState", errState, 3);
    chk("R11 done still", doneCnt, 1);
    chk("R11 no descErr", descErr, 0);
    runChain(32'h1000, 1'b0, 32'h100);
    chk("R2 start clears lenErr", lenErr, 0);
    chk("R2 start clears errState", errState, 0);
  endtask

  task automatic testAbort();
    memW(32'h1000, len32(16'h0100, A_LEN));
    memW(32'h1004, d32(32'h4000, A_XF | A_END));
    kick(32'h1000, 1'b0, 32'h100);
    while (!moveReq) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R12 busy low", busy, 0);
    chk("R12 moveReq low", moveReq, 0);
    repeat (6) @(negedge clk);
    chk("R12 no done", doneCnt, 0);
    chk("R12 no move", moveCnt, 0);
  endtask

  task automatic testStartBusy();
    buildChain32();
    kick(32'h1000, 1'b0, 32'h240);
    while (!moveReq) @(negedge clk);
    tableBase = 32'h3000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R13 move count", moveCnt, 2);
    chk("R13 move1 addr", moveLogA[1], 32'h7000);
    chk("R13 done count", doneCnt, 1);
    chk("R13 no lenErr", lenErr, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    clearLogs();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testChain32();
    testChain64();
    testInvalid();
    testFormat();
    testLength();
    testAbort();
    testStartBusy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule